// File: doc/BRIEF.md
# Serial FIFO Threshold Interrupt Controller

This block stores the programmable fill-level thresholds of a serial peripheral's transmit and receive FIFOs and produces two level interrupts from them. One interrupt says the transmit FIFO has drained to its threshold or below. The other says the receive FIFO holds more entries than its threshold. The FIFOs report their current entry counts, and the block compares those counts against the stored thresholds. The interrupt outputs are combinational, so they follow the counts in the same cycle and drop as soon as the condition ends.

Software reaches the block through a small word-wide register port. The port has a peripheral enable bit and the two threshold fields. A threshold may only be changed while the peripheral is disabled. A write whose value lies outside the range its FIFO depth allows is dropped, and the stored threshold keeps its old value.

Top module: `thrIrqCtrl`

## Requirements
- R1: After reset, the enable bit reads 0, and the transmit and receive thresholds both read 0.
- R2: The register map is as follows. The enable flag is bit 0 of offset 0x08. The transmit threshold is bits 5:0 of offset 0x18. The receive threshold is bits 5:0 of offset 0x1C. Every other bit, and every other offset, reads as 0.
- R3: While the enable bit is 1, a write to either threshold offset leaves that threshold unchanged.
- R4: While disabled, a write to offset 0x18 is accepted only when the whole 32-bit write value is below TX_DEPTH (64). Any other value leaves the transmit threshold unchanged.
- R5: While disabled, a write to offset 0x1C is accepted only when the whole 32-bit write value is at most RX_DEPTH (48). Any other value leaves the receive threshold unchanged.
- R6: `txEmptyIrq` is 1 in the same cycle exactly when `txLevel` is less than or equal to the transmit threshold. With a threshold of 0, it is 1 only when the FIFO is empty.
- R7: `rxFullIrq` is 1 in the same cycle exactly when `rxLevel` is greater than or equal to the receive threshold plus 1. With a threshold of 0, it is 1 at one entry or more.
- R8: A write to offset 0x08 is always accepted. It loads bit 0 of the write value into the enable flag, and the other bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for both reads and writes |
| wrData | input | 32 | Write value |
| rdData | output | 32 | Read value for `regAddr` (combinational) |
| txLevel | input | 7 | Current transmit FIFO entry count |
| rxLevel | input | 7 | Current receive FIFO entry count |
| txEmptyIrq | output | 1 | Transmit level at or below threshold |
| rxFullIrq | output | 1 | Receive level above threshold |

## Verification
The compares are tried with FIFO levels placed exactly at the threshold, one entry below it and one entry above it. This separates the inclusive transmit compare from the threshold-plus-one receive compare, and also exposes an off-by-one in either direction. Zero thresholds, full and empty FIFOs, and the largest legal thresholds show whether the comparison widths overflow. Threshold writes are issued while enabled, and with values just inside and just outside each depth limit, including values with reserved bits set. These tell apart the lock, the two range checks and their differing bounds. Random writes mixed with random levels then check the register state and both interrupts against a reference model.

// File: rtl/thrPkg.sv
package thrPkg;
  localparam int THR_W = 6;
  localparam int CNT_W = 7;

  typedef struct packed {
    logic enLoad;
    logic txLoad;
    logic rxLoad;
  } thrStrobes_t;
endpackage

// File: rtl/thrControl.sv
module thrControl
  import thrPkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 48,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] EN_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] TX_OFS = 8'h18,
  parameter logic [ADDR_W-1:0] RX_OFS = 8'h1C
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [THR_W-1:0] txThr,
  input  logic [THR_W-1:0] rxThr,
  output thrStrobes_t strobes,
  output logic [THR_W-1:0] wrValue,
  output logic enable,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [DATA_W-1:0] TX_LIMIT = DATA_W'(TX_DEPTH);
  localparam logic [DATA_W-1:0] RX_LIMIT = DATA_W'(RX_DEPTH);

  logic txInRange;
  logic rxInRange;
  logic hitEn;
  logic hitTx;
  logic hitRx;

  assign hitEn = (regAddr == EN_OFS);
  assign hitTx = (regAddr == TX_OFS);
  assign hitRx = (regAddr == RX_OFS);

  // Range check uses the full write word, so set reserved bits reject it.
  assign txInRange = (wrData < TX_LIMIT);
  assign rxInRange = (wrData <= RX_LIMIT);

  always_comb begin
    strobes.enLoad = wrEn && hitEn;
    strobes.txLoad = wrEn && hitTx && !enable && txInRange;
    strobes.rxLoad = wrEn && hitRx && !enable && rxInRange;
  end

  assign wrValue = wrData[THR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
    end else if (strobes.enLoad) begin
      enable <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    if (hitEn) begin
      rdData[0] = enable;
    end else if (hitTx) begin
      rdData[THR_W-1:0] = txThr;
    end else if (hitRx) begin
      rdData[THR_W-1:0] = rxThr;
    end
  end
endmodule

// File: rtl/thrDatapath.sv
module thrDatapath
  import thrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  thrStrobes_t strobes,
  input  logic [THR_W-1:0] wrValue,
  input  logic [CNT_W-1:0] txLevel,
  input  logic [CNT_W-1:0] rxLevel,
  output logic [THR_W-1:0] txThr,
  output logic [THR_W-1:0] rxThr,
  output logic txEmptyIrq,
  output logic rxFullIrq
);
  logic [CNT_W-1:0] rxTrip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThr <= '0;
      rxThr <= '0;
    end else begin
      if (strobes.txLoad) txThr <= wrValue;
      if (strobes.rxLoad) rxThr <= wrValue;
    end
  end

  // Widened sum: threshold plus one never wraps.
  assign rxTrip = CNT_W'(rxThr) + CNT_W'(1);

  assign txEmptyIrq = (txLevel <= CNT_W'(txThr));
  assign rxFullIrq = (rxLevel >= rxTrip);
endmodule

// File: rtl/thrIrqCtrl.sv
module thrIrqCtrl
  import thrPkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [7:0] regAddr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [6:0] txLevel,
  input  logic [6:0] rxLevel,
  output logic txEmptyIrq,
  output logic rxFullIrq
);
  thrStrobes_t strobes;
  logic [THR_W-1:0] wrValue;
  logic [THR_W-1:0] txThr;
  logic [THR_W-1:0] rxThr;
  logic enable;

  thrControl #(
    .TX_DEPTH(TX_DEPTH),
    .RX_DEPTH(RX_DEPTH),
    .ADDR_W(8),
    .DATA_W(32)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .regAddr(regAddr),
    .wrData(wrData),
    .txThr(txThr),
    .rxThr(rxThr),
    .strobes(strobes),
    .wrValue(wrValue),
    .enable(enable),
    .rdData(rdData)
  );

  thrDatapath dp_i (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .wrValue(wrValue),
    .txLevel(txLevel),
    .rxLevel(rxLevel),
    .txThr(txThr),
    .rxThr(rxThr),
    .txEmptyIrq(txEmptyIrq),
    .rxFullIrq(rxFullIrq)
  );
endmodule

// File: rtl/thrIrqChk.sv
module thrIrqChk #(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 48
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic [7:0] regAddr,
  input logic [31:0] wrData,
  input logic [6:0] txLevel,
  input logic [6:0] rxLevel,
  input logic txEmptyIrq,
  input logic rxFullIrq,
  input logic [5:0] txThr,
  input logic [5:0] rxThr,
  input logic enable
);
  // R3: thresholds frozen while enabled
  p_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> ($stable(txThr) && $stable(rxThr)));

  // R4: out-of-range transmit write dropped
  p_tx_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 8'h18 && wrData >= 32'(TX_DEPTH)) |=> $stable(txThr));

  // R5: out-of-range receive write dropped
  p_rx_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 8'h1C && wrData > 32'(RX_DEPTH)) |=> $stable(rxThr));

  // R5: stored receive threshold stays within depth
  p_rx_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    32'(rxThr) <= 32'(RX_DEPTH));

  // R6: an empty transmit FIFO always raises the interrupt
  p_tx_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == 7'd0) |-> txEmptyIrq);

  // R7: an empty receive FIFO never raises the interrupt
  p_rx_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == 7'd0) |-> !rxFullIrq);

  // R7: a full receive count above the max threshold always fires
  p_rx_top_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == 7'd64) |-> rxFullIrq);

  // R8: enable follows bit 0 of an enable write
  p_en_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 8'h08) |=> (enable == $past(wrData[0])));
endmodule

bind thrIrqCtrl thrIrqChk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) chk_i (
  .clk(clk),
  .rstN(rstN),
  .wrEn(wrEn),
  .regAddr(regAddr),
  .wrData(wrData),
  .txLevel(txLevel),
  .rxLevel(rxLevel),
  .txEmptyIrq(txEmptyIrq),
  .rxFullIrq(rxFullIrq),
  .txThr(txThr),
  .rxThr(rxThr),
  .enable(enable)
);

// File: tb/thrIrqCtrl_tb.sv
module thrIrqCtrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TX_DEPTH = 64;
  localparam int RX_DEPTH = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [6:0] txLevel = '0;
  logic [6:0] rxLevel = '0;
  logic txEmptyIrq;
  logic rxFullIrq;

  int checks = 0;
  int fails = 0;
  logic expEn = 1'b0;
  logic [5:0] expTx = '0;
  logic [5:0] expRx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thrIrqCtrl #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .txLevel(txLevel), .rxLevel(rxLevel),
    .txEmptyIrq(txEmptyIrq), .rxFullIrq(rxFullIrq)
  );

  function automatic logic expTxIrq(input logic [6:0] lvl, input logic [5:0] thr);
    return int'(lvl) <= int'(thr);
  endfunction

  function automatic logic expRxIrq(input logic [6:0] lvl, input logic [5:0] thr);
    return int'(lvl) >= int'(thr) + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 8'h08) expEn = d[0];
    else if (a == 8'h18 && !expEn && d < 32'(TX_DEPTH)) expTx = d[5:0];
    else if (a == 8'h1C && !expEn && d <= 32'(RX_DEPTH)) expRx = d[5:0];
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic regsCheck(input string req);
    readCheck(req, 8'h08, {31'b0, expEn});
    readCheck(req, 8'h18, {26'b0, expTx});
    readCheck(req, 8'h1C, {26'b0, expRx});
  endtask

  task automatic levelCheck(input logic [6:0] tl, input logic [6:0] rl);
    txLevel = tl; rxLevel = rl;
    #1;
    check("R6", {31'b0, txEmptyIrq}, {31'b0, expTxIrq(tl, expTx)});
    check("R7", {31'b0, rxFullIrq}, {31'b0, expRxIrq(rl, expRx)});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int unsigned seedInit;
    seedInit = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values
    regsCheck("R1");
    // R2: unmapped offset and reserved bits read zero
    readCheck("R2", 8'h10, 32'h0);
    doWrite(8'h18, 32'd5);
    readCheck("R2", 8'h18, 32'd5);
    // R6/R7 with threshold boundaries
    levelCheck(7'd5, 7'd0);
    levelCheck(7'd6, 7'd1);
    levelCheck(7'd0, 7'd64);
    // R8: only bit 0 kept
    doWrite(8'h08, 32'hFFFF_FFFF);
    readCheck("R8", 8'h08, 32'h1);
    // R3: writes locked while enabled
    doWrite(8'h18, 32'd9);
    doWrite(8'h1C, 32'd7);
    regsCheck("R3");
    doWrite(8'h08, 32'hFFFF_FFFE);
    readCheck("R8", 8'h08, 32'h0);
    // R4: transmit range limits
    doWrite(8'h18, 32'd64);
    readCheck("R4", 8'h18, 32'd5);
    doWrite(8'h18, 32'h0000_0103);
    readCheck("R4", 8'h18, 32'd5);
    doWrite(8'h18, 32'd63);
    readCheck("R4", 8'h18, 32'd63);
    levelCheck(7'd63, 7'd0);
    levelCheck(7'd64, 7'd0);
    // R5: receive range limits
    doWrite(8'h1C, 32'd49);
    readCheck("R5", 8'h1C, 32'd0);
    doWrite(8'h1C, 32'd48);
    readCheck("R5", 8'h1C, 32'd48);
    levelCheck(7'd0, 7'd48);
    levelCheck(7'd0, 7'd49);
    doWrite(8'h1C, 32'd3);
    levelCheck(7'd10, 7'd3);
    levelCheck(7'd10, 7'd4);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      case ($urandom_range(0, 3))
        0: a = 8'h08;
        1: a = 8'h18;
        2: a = 8'h1C;
        default: a = 8'h0C;
      endcase
      d = ($urandom_range(0, 7) == 0) ? $urandom() : 32'($urandom_range(0, 70));
      if (a == 8'h08) d = 32'($urandom_range(0, 3) == 0);
      doWrite(a, d);
      regsCheck("R3");
      levelCheck(7'($urandom_range(0, 64)), 7'($urandom_range(0, 64)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule